// File: doc/BRIEF.md
# Configurable I/O Macrocell with Product-Term Clocked Registers

This block is the per-pin cell of a programmable logic device meant for asynchronous designs. It takes a group of product terms from the AND array and ORs them into one sum term. It also takes a second product term that is XORed into the path of the output register. Static configuration bits make that output register act as a D, T, JK or RS flip-flop, set the output polarity, pick the output-enable source and pick which signal goes back to the array.

No global clock is used. The output register and the input register each take their clock edge, their asynchronous set and their asynchronous reset from their own product-term inputs. The input register captures the pad value, so the pin can be sampled on an edge that has nothing to do with the output path. The pad driver itself sits outside the block: the cell supplies the data to drive and the enable, and it receives the value on the pad.

Top module: `pld_io_macrocell`

## Requirements
- R1: The output register clears while `outRstPt` is high and goes to 1 while `outSetPt` is high. Both act at once, with no clock edge needed. When both are high, the register is 0.
- R2: With `cfgMode` = 2'b00 (D), a rising edge on `outClkPt` loads the sum term XOR `xorPt`.
- R3: With `cfgMode` = 2'b01 (T), a rising edge on `outClkPt` inverts the register when the sum term is 1 and keeps its value when the sum term is 0. In this mode `xorPt` has no effect.
- R4: With `cfgMode` = 2'b10 (JK), the sum term is J and `xorPt` is K. On a rising edge of `outClkPt` the register behaves as follows: J=0,K=0 keeps its value; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 inverts.
- R5: With `cfgMode` = 2'b11 (RS), the sum term is S and `xorPt` is R. On a rising edge of `outClkPt` the register keeps its value, sets or clears as S and R ask. When S and R are both 1, the register is cleared.
- R6: A rising edge on `inClkPt` makes the input register capture `padIn`. The input register has its own set (`inSetPt`) and reset (`inRstPt`), and reset wins over set. Edges, sets and resets of the output register leave it unchanged.
- R7: `padOut` is the output register value XOR `cfgInvert`.
- R8: `padOe` follows `cfgOeSel`: 2'b00 gives 0, 2'b01 gives 1, and 2'b10 or 2'b11 gives `oePt`.
- R9: `fbOut` follows `cfgFbSel`: 2'b00 gives the output register, 2'b01 gives the input register, and 2'b10 or 2'b11 gives `padIn`.
- R10: The sum term is 1 when at least one bit of `sumPts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgMode | input | 2 | Output register behaviour: D, T, JK or RS |
| cfgOeSel | input | 2 | Source of the output enable |
| cfgFbSel | input | 2 | Source of the signal fed back to the array |
| cfgInvert | input | 1 | Inverts the data sent to the pad |
| sumPts | input | NUM_SUM_TERMS | Product terms ORed into the sum term |
| xorPt | input | 1 | Second product term on the XOR path (K or R input) |
| outClkPt | input | 1 | Product-term clock of the output register |
| outSetPt | input | 1 | Product-term asynchronous set of the output register |
| outRstPt | input | 1 | Product-term asynchronous reset of the output register |
| oePt | input | 1 | Product-term output enable |
| inClkPt | input | 1 | Product-term clock of the input register |
| inSetPt | input | 1 | Product-term asynchronous set of the input register |
| inRstPt | input | 1 | Product-term asynchronous reset of the input register |
| padIn | input | 1 | Value present on the pad |
| padOut | output | 1 | Data for the pad driver |
| padOe | output | 1 | Enable for the pad driver |
| fbOut | output | 1 | Feedback signal to the AND array |

## Verification
The bench builds the cell with four sum product terms instead of the default eight. This keeps the random patterns small enough that an all-zero sum term comes up often, next to single-bit and multi-bit OR cases. The bench keeps a model of both registers. Each mode of the output register runs against random J/K, S/R and T inputs, mixed with random asynchronous set and reset pulses and independent input-register edges. Directed cases cover the forbidden RS input, the JK toggle, set and reset asserted together, and the XOR term being ignored in T mode.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  // Output register behaviour selected by configuration
  typedef enum logic [1:0] {
    MODE_D  = 2'b00,
    MODE_T  = 2'b01,
    MODE_JK = 2'b10,
    MODE_RS = 2'b11
  } regMode_e;

  // Decoded strobes from control to datapath
  typedef struct packed {
    logic selD;
    logic selT;
    logic selJk;
    logic selRs;
    logic oeForceOn;
    logic oeFollowPt;
    logic fbOutReg;
    logic fbInReg;
    logic fbPad;
  } mcStrobe_t;

endpackage

// File: rtl/pld_mc_ctrl.sv
module pld_mc_ctrl
  import pld_mc_pkg::*;
(
  input  logic [1:0] cfgMode,
  input  logic [1:0] cfgOeSel,
  input  logic [1:0] cfgFbSel,
  output mcStrobe_t  strobe
);

  regMode_e modeSel;

  assign modeSel = regMode_e'(cfgMode);

  always_comb begin
    strobe = '0;
    case (modeSel)
      MODE_T:  strobe.selT  = 1'b1;
      MODE_JK: strobe.selJk = 1'b1;
      MODE_RS: strobe.selRs = 1'b1;
      default: strobe.selD  = 1'b1;
    endcase
    // upper bit of the OE select hands control to the product term
    strobe.oeFollowPt = cfgOeSel[1];
    strobe.oeForceOn  = (cfgOeSel == 2'b01);
    strobe.fbPad      = cfgFbSel[1];
    strobe.fbInReg    = (cfgFbSel == 2'b01);
    strobe.fbOutReg   = (cfgFbSel == 2'b00);
  end

endmodule

// File: rtl/pld_mc_datapath.sv
module pld_mc_datapath
  import pld_mc_pkg::*;
#(
  parameter int NUM_SUM_TERMS = 8
) (
  input  mcStrobe_t                 strobe,
  input  logic                      cfgInvert,
  input  logic [NUM_SUM_TERMS-1:0]  sumPts,
  input  logic                      xorPt,
  input  logic                      outClkPt,
  input  logic                      outSetPt,
  input  logic                      outRstPt,
  input  logic                      oePt,
  input  logic                      inClkPt,
  input  logic                      inSetPt,
  input  logic                      inRstPt,
  input  logic                      padIn,
  output logic                      padOut,
  output logic                      padOe,
  output logic                      fbOut
);

  logic sumTerm;
  logic xorBase;
  logic xorOperand;
  logic dNext;
  logic outQ;
  logic inQ;

  assign sumTerm = |sumPts;

  // One XOR feeds the D input; the mode chooses both of its operands
  always_comb begin
    xorBase    = sumTerm;
    xorOperand = xorPt;
    if (strobe.selT) begin
      xorOperand = outQ;
    end else if (strobe.selJk) begin
      xorBase    = outQ;
      xorOperand = outQ ? xorPt : sumTerm;
    end else if (strobe.selRs) begin
      xorBase    = outQ;
      xorOperand = outQ ? xorPt : (sumTerm & ~xorPt);
    end
    dNext = xorBase ^ xorOperand;
  end

  // Output register: own clock, set and reset; reset dominates
  always_ff @(posedge outClkPt or posedge outRstPt or posedge outSetPt) begin
    if (outRstPt)      outQ <= 1'b0;
    else if (outSetPt) outQ <= 1'b1;
    else               outQ <= dNext;
  end

  // Input register: captures the pad on its own product-term edge
  always_ff @(posedge inClkPt or posedge inRstPt or posedge inSetPt) begin
    if (inRstPt)      inQ <= 1'b0;
    else if (inSetPt) inQ <= 1'b1;
    else              inQ <= padIn;
  end

  assign padOut = outQ ^ cfgInvert;
  assign padOe  = strobe.oeFollowPt ? oePt : strobe.oeForceOn;

  always_comb begin
    if (strobe.fbPad)        fbOut = padIn;
    else if (strobe.fbInReg) fbOut = inQ;
    else                     fbOut = outQ;
  end

  // R1
  out_set_hold_chk: assert property (@(negedge outClkPt) disable iff (outRstPt)
    outSetPt |-> outQ);

  // R1
  out_rst_dom_chk: assert property (@(negedge outClkPt) disable iff (!outRstPt)
    outSetPt |-> !outQ);

  // R6
  in_rst_dom_chk: assert property (@(negedge inClkPt) disable iff (!inRstPt)
    1'b1 |-> !inQ);

endmodule

// File: rtl/pld_io_macrocell.sv
module pld_io_macrocell
  import pld_mc_pkg::*;
#(
  parameter int NUM_SUM_TERMS = 8
) (
  input  logic [1:0]               cfgMode,
  input  logic [1:0]               cfgOeSel,
  input  logic [1:0]               cfgFbSel,
  input  logic                     cfgInvert,
  input  logic [NUM_SUM_TERMS-1:0] sumPts,
  input  logic                     xorPt,
  input  logic                     outClkPt,
  input  logic                     outSetPt,
  input  logic                     outRstPt,
  input  logic                     oePt,
  input  logic                     inClkPt,
  input  logic                     inSetPt,
  input  logic                     inRstPt,
  input  logic                     padIn,
  output logic                     padOut,
  output logic                     padOe,
  output logic                     fbOut
);

  mcStrobe_t strobe;

  pld_mc_ctrl u_ctrl (
    .cfgMode  (cfgMode),
    .cfgOeSel (cfgOeSel),
    .cfgFbSel (cfgFbSel),
    .strobe   (strobe)
  );

  pld_mc_datapath #(
    .NUM_SUM_TERMS (NUM_SUM_TERMS)
  ) u_dp (
    .strobe    (strobe),
    .cfgInvert (cfgInvert),
    .sumPts    (sumPts),
    .xorPt     (xorPt),
    .outClkPt  (outClkPt),
    .outSetPt  (outSetPt),
    .outRstPt  (outRstPt),
    .oePt      (oePt),
    .inClkPt   (inClkPt),
    .inSetPt   (inSetPt),
    .inRstPt   (inRstPt),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .fbOut     (fbOut)
  );

  always_comb begin
    // R8
    oe_off_chk: assert (cfgOeSel != 2'b00 || !padOe);
    // R8
    oe_on_chk: assert (cfgOeSel != 2'b01 || padOe);
    // R9
    fb_pad_chk: assert (!cfgFbSel[1] || fbOut == padIn);
  end

endmodule

// File: tb/tb_pld_io_macrocell.sv
module tb_pld_io_macrocell;

  localparam int NT = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    cfgMode = '0, cfgOeSel = '0, cfgFbSel = '0;
  logic          cfgInvert = 1'b0;
  logic [NT-1:0] sumPts = '0;
  logic xorPt = 0, outClkPt = 0, outSetPt = 0, outRstPt = 0, oePt = 0;
  logic inClkPt = 0, inSetPt = 0, inRstPt = 0, padIn = 0;
  logic padOut, padOe, fbOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic expOut = 0;
  logic expIn = 0;

  pld_io_macrocell #(.NUM_SUM_TERMS(NT)) dut (
    .cfgMode(cfgMode), .cfgOeSel(cfgOeSel), .cfgFbSel(cfgFbSel),
    .cfgInvert(cfgInvert), .sumPts(sumPts), .xorPt(xorPt),
    .outClkPt(outClkPt), .outSetPt(outSetPt), .outRstPt(outRstPt),
    .oePt(oePt), .inClkPt(inClkPt), .inSetPt(inSetPt), .inRstPt(inRstPt),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  function automatic logic nextQ(logic [1:0] m, logic s, logic x, logic q);
    case (m)
      2'b00:   return s ^ x;
      2'b01:   return s ? ~q : q;
      2'b10:   return (s & ~q) | (~x & q);
      default: return x ? 1'b0 : (s ? 1'b1 : q);
    endcase
  endfunction

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic expOe();
    return cfgOeSel[1] ? oePt : (cfgOeSel == 2'b01);
  endfunction

  function automatic logic expFb();
    if (cfgFbSel[1]) return padIn;
    if (cfgFbSel == 2'b01) return expIn;
    return expOut;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // check every output against the model
  task automatic checkAll(string req);
    @(negedge clk); #1;
    check(req, padOut, expOut ^ cfgInvert);
    check("R8", padOe, expOe());
    check("R9", fbOut, expFb());
  endtask

  task automatic pulseOutClk();
    @(posedge clk); #2;
    outClkPt = 1'b1; #1; outClkPt = 1'b0;
    expOut = nextQ(cfgMode, |sumPts, xorPt, expOut);
  endtask

  task automatic pulseInClk();
    @(posedge clk); #2;
    inClkPt = 1'b1; #1; inClkPt = 1'b0;
    expIn = padIn;
  endtask

  task automatic outCycle(logic [1:0] m, logic [NT-1:0] s, logic x, string req);
    @(posedge clk); #1;
    cfgMode = m; sumPts = s; xorPt = x;
    pulseOutClk();
    checkAll(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #10;
    // reset state of both registers (R1, R6)
    outRstPt = 1; inRstPt = 1; #3; outRstPt = 0; inRstPt = 0;
    expOut = 0; expIn = 0;
    cfgFbSel = 2'b00; checkAll("R1");
    cfgFbSel = 2'b01; checkAll("R6");

    // R1: set, then reset while set held, then release both
    @(posedge clk); #1; outSetPt = 1; expOut = 1; cfgFbSel = 2'b00; checkAll("R1");
    @(posedge clk); #1; outRstPt = 1; expOut = 0; checkAll("R1");
    @(posedge clk); #1; outSetPt = 0; outRstPt = 0; checkAll("R1");
    // R1: clock edge while reset held leaves 0
    @(posedge clk); #1; outRstPt = 1; cfgMode = 2'b00; sumPts = 4'b0001; xorPt = 0;
    outClkPt = 1; #1; outClkPt = 0; #1; outRstPt = 0; checkAll("R1");

    // R2 D mode
    outCycle(2'b00, 4'b0100, 1'b0, "R2");
    outCycle(2'b00, 4'b0100, 1'b1, "R2");
    outCycle(2'b00, 4'b0000, 1'b1, "R2");
    // R10 one term at each position
    for (int i = 0; i < NT; i++) outCycle(2'b00, NT'(1) << i, 1'b0, "R10");
    outCycle(2'b00, 4'b0000, 1'b0, "R10");
    // R3 T mode: toggle, hold, xorPt ignored
    outCycle(2'b01, 4'b0010, 1'b0, "R3");
    outCycle(2'b01, 4'b0000, 1'b1, "R3");
    outCycle(2'b01, 4'b1000, 1'b1, "R3");
    // R4 JK all four combinations, toggle twice
    outCycle(2'b10, 4'b0001, 1'b0, "R4");
    outCycle(2'b10, 4'b0000, 1'b0, "R4");
    outCycle(2'b10, 4'b0001, 1'b1, "R4");
    outCycle(2'b10, 4'b0001, 1'b1, "R4");
    outCycle(2'b10, 4'b0000, 1'b1, "R4");
    // R5 RS including forbidden input from both states
    outCycle(2'b11, 4'b0001, 1'b0, "R5");
    outCycle(2'b11, 4'b0011, 1'b1, "R5");
    outCycle(2'b11, 4'b0001, 1'b0, "R5");
    outCycle(2'b11, 4'b0000, 1'b0, "R5");
    outCycle(2'b11, 4'b0000, 1'b1, "R5");
    outCycle(2'b11, 4'b0001, 1'b1, "R5");

    // R6 input register capture, independence, set/reset
    cfgFbSel = 2'b01;
    @(posedge clk); #1; padIn = 1; pulseInClk(); checkAll("R6");
    @(posedge clk); #1; padIn = 0; checkAll("R6");
    outCycle(2'b01, 4'b0001, 1'b0, "R6");
    @(posedge clk); #1; outSetPt = 1; expOut = 1; #1; outSetPt = 0; checkAll("R6");
    @(posedge clk); #1; inSetPt = 1; inRstPt = 1; expIn = 0; #2;
    inSetPt = 0; inRstPt = 0; checkAll("R6");
    @(posedge clk); #1; inSetPt = 1; expIn = 1; #2; inSetPt = 0; checkAll("R6");

    // R7 polarity, R8 OE modes, R9 feedback pad
    cfgInvert = 1; cfgFbSel = 2'b10; padIn = 1; checkAll("R7");
    cfgOeSel = 2'b01; checkAll("R8");
    cfgOeSel = 2'b10; oePt = 1; checkAll("R8");
    cfgOeSel = 2'b11; oePt = 0; cfgFbSel = 2'b11; padIn = 0; checkAll("R9");

    // random mix
    for (int it = 0; it < 400; it++) begin
      @(posedge clk); #1;
      cfgMode   = 2'($urandom);
      cfgOeSel  = 2'($urandom);
      cfgFbSel  = 2'($urandom);
      cfgInvert = 1'($urandom);
      sumPts    = ($urandom % 3 == 0) ? '0 : NT'($urandom);
      xorPt     = 1'($urandom);
      oePt      = 1'($urandom);
      padIn     = 1'($urandom);
      case ($urandom % 16)
        0: begin outRstPt = 1; expOut = 0; #1; outRstPt = 0; end
        1: begin outSetPt = 1; expOut = 1; #1; outSetPt = 0; end
        2: begin inRstPt = 1; expIn = 0; #1; inRstPt = 0; end
        3: begin inSetPt = 1; expIn = 1; #1; inSetPt = 0; end
        default: ;
      endcase
      if ($urandom % 4 != 0) pulseOutClk();
      if ($urandom % 2 == 0) pulseInClk();
      checkAll(modeTag(cfgMode));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule